// File: doc/BRIEF.md
# Expansion-Bus Slave to Wishbone Bridge

This block sits between the slave side of a host expansion bus and an internal Wishbone classic bus. A host transfer is opened with a one-cycle start pulse that carries a byte address, a direction and a 3-bit burst-length code. The bridge breaks the transfer into single Wishbone accesses, one for each 32-bit word. Each access goes to the next word address, wrapping inside the naturally aligned burst block. Each completed word is reported back to the host with a one-cycle acknowledge code.

Write data is taken straight from the host data input. The host moves on to the next word after it sees each acknowledge. Read data is registered and presented together with the word acknowledge.

A configurable address window can be marked read-only, so that an identification ROM and writable register banks can share the bridge. A write into that window is refused with an error and never reaches Wishbone. Unsupported length codes and Wishbone error responses also end the transfer with the error code.

Top module: `hostbus_wb_bridge`

## Requirements
- R1: After reset `h_ack` is 00, `h_busy` is 0 and `wb_cyc_o`/`wb_stb_o` are 0.
- R2: A start with length code 0, 1, 2, 3 or 4 moves exactly 1, 2, 4, 8 or 16 words. Each word completed on Wishbone (ack) gives `h_ack` = 01 in the following cycle.
- R3: A start with length code 5, 6 or 7 produces `h_ack` = 11 for one cycle in the following cycle and no Wishbone cycle.
- R4: The first Wishbone address is `h_addr` with bits [1:0] cleared. Each following word adds 4, wrapping modulo the block size (words × 4 bytes) inside the aligned block.
- R5: For a write, each Wishbone access has `wb_we_o` = 1, `wb_sel_o` all ones, and `wb_dat_o` equal to the host word for that position. The host presents the next word after each 01 acknowledge.
- R6: For a read, `h_rdata` during a 01 acknowledge equals the `wb_dat_i` returned for that word.
- R7: A Wishbone error on any word gives `h_ack` = 11 in the following cycle, ends the transfer (`h_busy` low), and starts no further Wishbone access.
- R8: At most one Wishbone access is open at a time. Once raised, `wb_stb_o` stays high with a stable address until ack or err.
- R9: A write whose address matches the read-only window (default: bits [15:12] equal 0) gets `h_ack` = 11 and is not forwarded. A read from that window proceeds normally.
- R10: `h_ack` is never non-idle in two consecutive cycles. A start pulse while `h_busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_start | input | 1 | One-cycle transfer start |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_size | input | 3 | Burst length code |
| h_addr | input | AW | Byte address of first word |
| h_wdata | input | DW | Host write word for the current position |
| h_rdata | output | DW | Read word, valid with a 01 acknowledge |
| h_ack | output | 2 | 00 idle, 01 word done, 11 error |
| h_busy | output | 1 | Transfer in progress |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_adr_o | output | AW | Wishbone byte address |
| wb_sel_o | output | DW/8 | Wishbone byte selects |
| wb_dat_o | output | DW | Wishbone write data |
| wb_dat_i | input | DW | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| wb_err_i | input | 1 | Wishbone error |

## Verification
The bench starts bursts at offsets inside the block, so an address sequencer that carries past the block boundary instead of wrapping touches the wrong words and fails the per-access address check. It injects a Wishbone error in the middle of a burst. A bridge that keeps going after the error is caught by the access count, and one that stops without signalling is caught by the cycle-exact acknowledge comparison. Writes into the read-only window and the three illegal length codes must yield a lone error and zero Wishbone traffic, with later read-back showing memory untouched. A second start pulse raised mid-burst must neither restart nor extend the running transfer.

// File: rtl/hwb_pkg.sv
package hwb_pkg;

    localparam int SZ_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_STEP = 2'd2
    } hwb_state_e;

    localparam logic [1:0] HACK_IDLE = 2'b00;
    localparam logic [1:0] HACK_WORD = 2'b01;
    localparam logic [1:0] HACK_ERR  = 2'b11;

endpackage

// File: rtl/hwb_size_decode.sv
module hwb_size_decode #(
    parameter int MAX_LOG = 4,
    parameter int CNTW    = MAX_LOG + 1,
    parameter int SPANW   = MAX_LOG + 3
) (
    input  logic [hwb_pkg::SZ_W-1:0] code,
    output logic                     ok,
    output logic [CNTW-1:0]          words_m1,
    output logic [SPANW-1:0]         span_m1
);
    // Legal codes select 2**code words; bytes in the block are words*4.
    always_comb begin
        ok = (code <= hwb_pkg::SZ_W'(MAX_LOG));
        if (ok) begin
            words_m1 = CNTW'((CNTW'(1) << code) - CNTW'(1));
        end else begin
            words_m1 = '0;
        end
        span_m1 = {words_m1, 2'b11};
    end
endmodule

// File: rtl/hwb_addr_step.sv
module hwb_addr_step #(
    parameter int AW    = 16,
    parameter int SPANW = 7
) (
    input  logic [AW-1:0]    cur,
    input  logic [SPANW-1:0] span_m1,
    output logic [AW-1:0]    nxt
);
    localparam logic [AW-1:0] WORD_BYTES = AW'(4);

    logic [AW-1:0] mask_ext;
    logic [AW-1:0] inc;

    // Upper bits stay fixed, lower bits roll over inside the aligned block.
    always_comb begin
        mask_ext = {{(AW-SPANW){1'b0}}, span_m1};
        inc      = cur + WORD_BYTES;
        nxt      = (cur & ~mask_ext) | (inc & mask_ext);
    end
endmodule

// File: rtl/hostbus_wb_bridge.sv
module hostbus_wb_bridge #(
    parameter int          AW      = 16,
    parameter int          DW      = 32,
    parameter int          MAX_LOG = 4,
    parameter bit          RO_EN   = 1'b1,
    parameter logic [15:0] RO_MASK = 16'hF000,
    parameter logic [15:0] RO_BASE = 16'h0000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     h_start,
    input  logic                     h_wr,
    input  logic [hwb_pkg::SZ_W-1:0] h_size,
    input  logic [AW-1:0]            h_addr,
    input  logic [DW-1:0]            h_wdata,
    output logic [DW-1:0]            h_rdata,
    output logic [1:0]               h_ack,
    output logic                     h_busy,
    output logic                     wb_cyc_o,
    output logic                     wb_stb_o,
    output logic                     wb_we_o,
    output logic [AW-1:0]            wb_adr_o,
    output logic [DW/8-1:0]          wb_sel_o,
    output logic [DW-1:0]            wb_dat_o,
    input  logic [DW-1:0]            wb_dat_i,
    input  logic                     wb_ack_i,
    input  logic                     wb_err_i
);
    import hwb_pkg::*;

    localparam int CNTW  = MAX_LOG + 1;
    localparam int SPANW = MAX_LOG + 3;
    localparam logic [AW-1:0] LOW_CLR = ~AW'(3);

    typedef struct packed {
        hwb_state_e       st;
        logic [AW-1:0]    addr;
        logic [CNTW-1:0]  left;
        logic [SPANW-1:0] span;
        logic             we;
        logic [1:0]       ack;
        logic [DW-1:0]    rdata;
    } regs_t;

    regs_t q, d;

    logic             sz_ok;
    logic [CNTW-1:0]  sz_words_m1;
    logic [SPANW-1:0] sz_span_m1;
    logic [AW-1:0]    addr_next;
    logic             ro_hit;

    hwb_size_decode #(
        .MAX_LOG (MAX_LOG),
        .CNTW    (CNTW),
        .SPANW   (SPANW)
    ) size_dec_i (
        .code     (h_size),
        .ok       (sz_ok),
        .words_m1 (sz_words_m1),
        .span_m1  (sz_span_m1)
    );

    hwb_addr_step #(
        .AW    (AW),
        .SPANW (SPANW)
    ) addr_step_i (
        .cur     (q.addr),
        .span_m1 (q.span),
        .nxt     (addr_next)
    );

    generate
        if (RO_EN) begin : g_ro_window
            assign ro_hit = ((h_addr & AW'(RO_MASK)) == AW'(RO_BASE));
        end else begin : g_no_ro_window
            assign ro_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        d     = q;
        d.ack = HACK_IDLE;
        unique case (q.st)
            ST_IDLE: begin
                if (h_start) begin
                    if (!sz_ok || (h_wr && ro_hit)) begin
                        d.ack = HACK_ERR;
                    end else begin
                        d.st   = ST_REQ;
                        d.addr = h_addr & LOW_CLR;
                        d.left = sz_words_m1;
                        d.span = sz_span_m1;
                        d.we   = h_wr;
                    end
                end
            end
            ST_REQ: begin
                if (wb_err_i) begin
                    d.ack = HACK_ERR;
                    d.st  = ST_IDLE;
                end else if (wb_ack_i) begin
                    d.ack = HACK_WORD;
                    if (!q.we) begin
                        d.rdata = wb_dat_i;
                    end
                    if (q.left == '0) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.st   = ST_STEP;
                        d.left = q.left - CNTW'(1);
                        d.addr = addr_next;
                    end
                end
            end
            ST_STEP: begin
                d.st = ST_REQ;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, addr: '0, left: '0, span: '0, we: 1'b0,
                   ack: HACK_IDLE, rdata: '0};
        end else begin
            q <= d;
        end
    end

    assign h_ack    = q.ack;
    assign h_rdata  = q.rdata;
    assign h_busy   = (q.st != ST_IDLE);
    assign wb_cyc_o = (q.st == ST_REQ);
    assign wb_stb_o = (q.st == ST_REQ);
    assign wb_we_o  = q.we;
    assign wb_adr_o = q.addr;
    assign wb_sel_o = '1;
    assign wb_dat_o = h_wdata;

    p_word_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && wb_ack_i && !wb_err_i) |=> (h_ack == HACK_WORD));

    p_bad_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_start && !h_busy && (h_size > SZ_W'(MAX_LOG)))
        |=> (h_ack == HACK_ERR && !wb_cyc_o));

    p_err_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && wb_err_i) |=> (h_ack == HACK_ERR && !h_busy && !wb_cyc_o));

    p_stb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && !wb_ack_i && !wb_err_i) |=> (wb_stb_o && $stable(wb_adr_o)));

    p_ro_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_start && !h_busy && h_wr && ro_hit) |=> (h_ack == HACK_ERR && !wb_cyc_o));

    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ack != HACK_IDLE) |=> (h_ack == HACK_IDLE));

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (h_ack == HACK_IDLE && !h_busy && !wb_cyc_o));

endmodule

// File: tb/hostbus_wb_bridge_tb.sv
module hostbus_wb_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_start = 1'b0;
    logic        h_wr = 1'b0;
    logic [2:0]  h_size = 3'd0;
    logic [15:0] h_addr = 16'h0;
    logic [31:0] h_wdata = 32'h0;
    logic [31:0] h_rdata;
    logic [1:0]  h_ack;
    logic        h_busy;
    logic        wb_cyc_o, wb_stb_o, wb_we_o;
    logic [15:0] wb_adr_o;
    logic [3:0]  wb_sel_o;
    logic [31:0] wb_dat_o;
    logic [31:0] wb_dat_i = 32'h0;
    logic        wb_ack_i = 1'b0;
    logic        wb_err_i = 1'b0;

    always #10 clk = ~clk;

    hostbus_wb_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .h_start(h_start), .h_wr(h_wr),
        .h_size(h_size), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_ack(h_ack), .h_busy(h_busy),
        .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
        .wb_adr_o(wb_adr_o), .wb_sel_o(wb_sel_o), .wb_dat_o(wb_dat_o),
        .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i), .wb_err_i(wb_err_i)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] mem [0:4095];
    logic [15:0] aq[$];
    logic [31:0] dq[$];
    logic [31:0] hq[$];
    logic [31:0] xq[$];

    bit          running = 0;
    bit          cur_wr = 0;
    int          wcfg = 0;
    int          wcnt = 0;
    bit          err_en = 0;
    logic [15:0] err_addr = 16'h0;
    int          acks = 0;
    int          errs = 0;
    int          accesses = 0;
    bit          pend_ack = 0;
    bit          pend_err = 0;
    bit          pend_bad = 0;
    int          burst_id = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle monitor, host model and Wishbone slave model.
    always @(negedge clk) begin
        if (rst_n && running) begin
            logic [1:0] exp_ack;
            exp_ack = pend_ack ? 2'b01 : ((pend_err || pend_bad) ? 2'b11 : 2'b00);
            chk(h_ack == exp_ack, "R10", "h_ack per cycle", h_ack, exp_ack);
            if (h_ack == 2'b01) begin
                acks++;
                if (!cur_wr) begin
                    if (xq.size() > 0) begin
                        chk(h_rdata == xq[0], "R6", "h_rdata", h_rdata, xq[0]);
                        void'(xq.pop_front());
                    end
                end else if (hq.size() > 0) begin
                    void'(hq.pop_front());
                    h_wdata = (hq.size() > 0) ? hq[0] : 32'h0;
                end
            end
            if (h_ack == 2'b11) errs++;

            if (wb_ack_i || wb_err_i) begin
                wb_ack_i = 1'b0;
                wb_err_i = 1'b0;
            end else if (wb_cyc_o && wb_stb_o) begin
                if (wcnt >= wcfg) begin
                    wcnt = 0;
                    accesses++;
                    if (aq.size() > 0) begin
                        chk(wb_adr_o == aq[0], "R4", "wb_adr_o", wb_adr_o, aq[0]);
                        void'(aq.pop_front());
                    end else begin
                        chk(1'b0, "R7", "unexpected wb access", wb_adr_o, 0);
                    end
                    if (err_en && wb_adr_o == err_addr) begin
                        wb_err_i = 1'b1;
                    end else begin
                        wb_ack_i = 1'b1;
                        if (wb_we_o) begin
                            chk(wb_sel_o == 4'hF, "R5", "wb_sel_o", wb_sel_o, 4'hF);
                            if (dq.size() > 0) begin
                                chk(wb_dat_o == dq[0], "R5", "wb_dat_o", wb_dat_o, dq[0]);
                                void'(dq.pop_front());
                            end
                            mem[wb_adr_o[13:2]] = wb_dat_o;
                        end else begin
                            wb_dat_i = mem[wb_adr_o[13:2]];
                        end
                    end
                end else begin
                    wcnt++;
                end
            end
            pend_ack = wb_ack_i;
            pend_err = wb_err_i;
            pend_bad = h_start && !h_busy &&
                       ((h_size > 3'd4) || (h_wr && h_addr[15:12] == 4'h0));
        end
    end

    task automatic burst(input logic [15:0] addr, input logic [2:0] code,
                         input bit wr, input int wt, input bit inj_err,
                         input logic [15:0] eaddr, input bit extra,
                         input string req);
        int n;
        int span;
        int exp_words;
        bit exp_err;
        logic [15:0] base;
        logic [15:0] off;
        burst_id++;
        n = (code <= 3'd4) ? (1 << code) : 0;
        if (wr && addr[15:12] == 4'h0) n = 0;
        span = (n > 0) ? n * 4 : 4;
        base = addr & ~16'(span - 1);
        off  = addr & 16'(span - 1) & 16'hFFFC;
        aq.delete(); dq.delete(); hq.delete(); xq.delete();
        exp_words = n;
        exp_err = (n == 0);
        for (int i = 0; i < n; i++) begin
            logic [15:0] a;
            logic [31:0] v;
            a = base | ((off + 16'(4 * i)) & 16'(span - 1));
            aq.push_back(a);
            v = 32'hC0DE_0000 + 32'(burst_id * 256 + i);
            if (wr) begin
                dq.push_back(v);
                hq.push_back(v);
            end
            if (inj_err && a == eaddr && !exp_err) begin
                exp_words = i;
                exp_err = 1;
            end
        end
        for (int i = 0; i < exp_words; i++) begin
            if (!wr) xq.push_back(mem[aq[i][13:2]]);
        end
        acks = 0; errs = 0; accesses = 0;
        wcfg = wt; wcnt = 0;
        err_en = inj_err; err_addr = eaddr;
        cur_wr = wr;
        @(posedge clk); #2;
        h_wdata = (hq.size() > 0) ? hq[0] : 32'h0;
        h_start = 1'b1; h_addr = addr; h_size = code; h_wr = wr;
        @(posedge clk); #2;
        h_start = 1'b0;
        for (int c = 0; c < 400 && h_busy; c++) begin
            @(posedge clk); #2;
            if (extra && c == 3) begin
                h_start = 1'b1; h_addr = 16'h3300; h_size = 3'd0; h_wr = 1'b0;
            end else begin
                h_start = 1'b0;
            end
        end
        h_start = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk(acks == exp_words, req, "word acks", acks, exp_words);
        chk(errs == (exp_err ? 1 : 0), req, "error acks", errs, exp_err ? 1 : 0);
        chk(accesses == (exp_err && n > 0 ? exp_words + 1 : exp_words), req,
            "wb accesses", accesses, (exp_err && n > 0) ? exp_words + 1 : exp_words);
        chk(!h_busy && !wb_cyc_o, req, "idle after burst", h_busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'hA500_0000 ^ (32'(i) * 32'h0001_0101);
        repeat (3) @(negedge clk);
        chk(h_ack == 2'b00 && !h_busy && !wb_cyc_o && !wb_stb_o, "R1",
            "reset outputs", {h_ack, h_busy, wb_cyc_o}, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        running = 1;
        @(negedge clk);
        chk(h_ack == 2'b00 && !h_busy && !wb_cyc_o, "R1", "after reset", h_ack, 0);

        // R2 / R5: every legal length, writes, varied wait states and offsets
        burst(16'h1004, 3'd0, 1, 0, 0, 16'h0, 0, "R2");
        burst(16'h1104, 3'd1, 1, 1, 0, 16'h0, 0, "R2");
        burst(16'h1238, 3'd2, 1, 0, 0, 16'h0, 0, "R4");
        burst(16'h1314, 3'd3, 1, 2, 0, 16'h0, 0, "R4");
        burst(16'h1428, 3'd4, 1, 1, 0, 16'h0, 0, "R2");
        // R6: read back the written words through the same wrap pattern
        burst(16'h1004, 3'd0, 0, 1, 0, 16'h0, 0, "R6");
        burst(16'h1104, 3'd1, 0, 0, 0, 16'h0, 0, "R6");
        burst(16'h1238, 3'd2, 0, 2, 0, 16'h0, 0, "R6");
        burst(16'h1314, 3'd3, 0, 0, 0, 16'h0, 0, "R6");
        burst(16'h1428, 3'd4, 0, 0, 0, 16'h0, 0, "R6");
        // R9: read-only window readable, writes refused
        burst(16'h0040, 3'd3, 0, 1, 0, 16'h0, 0, "R9");
        burst(16'h0100, 3'd1, 1, 0, 0, 16'h0, 0, "R9");
        burst(16'h0100, 3'd1, 0, 0, 0, 16'h0, 0, "R9");
        // R3: illegal length codes
        burst(16'h2000, 3'd5, 0, 0, 0, 16'h0, 0, "R3");
        burst(16'h2000, 3'd6, 1, 0, 0, 16'h0, 0, "R3");
        burst(16'h2000, 3'd7, 0, 0, 0, 16'h0, 0, "R3");
        // R7: Wishbone error in the middle of a burst, then a clean read-back
        burst(16'h2000, 3'd3, 1, 1, 1, 16'h2008, 0, "R7");
        burst(16'h2000, 3'd3, 0, 0, 0, 16'h0, 0, "R7");
        burst(16'h2104, 3'd2, 0, 0, 1, 16'h2104, 0, "R7");
        // R8: long wait states keep the strobe held
        burst(16'h2200, 3'd1, 0, 5, 0, 16'h0, 0, "R8");
        // R10: second start during a burst is ignored
        burst(16'h2418, 3'd3, 0, 2, 0, 16'h0, 1, "R10");
        burst(16'h3300, 3'd0, 0, 0, 0, 16'h0, 0, "R10");

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule